// File: doc/BRIEF.md
# Partitioned Indirect Transfer Buffer

This block holds a single word-wide buffer array that is divided at a programmable boundary into two circular regions. The lower region is the read region: it carries words from the flash side to the host. The upper region is the write region: it carries words from the host to the flash side. Two words at the top of the array are kept out of both regions. The host moves words through a memory-mapped data port. It pushes words into the write region and pops words from the read region, both in FIFO order.

Each direction is controlled through a small register port. The host loads a byte count and a start address, then sets a start bit. A per-direction controller counts the bytes down by up to four per word. It keeps a busy flag while the transfer runs and raises a done flag that the host clears by writing 1. A built-in flash-side stand-in produces read words from the transfer address and consumes write words, presenting each one as a flash write on an output strobe. The last word of a transfer is always a full 32-bit word; bytes beyond the remaining count are zero.

Top module: `sbuf_xfer_buffer`

## Requirements
- R1: After reset both fill levels, both busy and done flags and the error bits read 0, and the partition register reads 64.
- R2: Register index 0 sets the read-region size in words, and the write region gets 126 minus that value. A written value above 126 is stored as 126. An accepted write empties both regions.
- R3: A write to the partition register while either direction is busy leaves the partition unchanged.
- R4: Register index 1 reports the read-region fill level in bits [15:0] and the write-region fill level in bits [31:16], in words.
- R5: Each control register (index 2 for read, 5 for write) has start at bit 0, cancel at bit 1, busy at bit 2 (read-only) and done at bit 5. Writing 1 to bit 5 clears done. A start while busy is ignored. The byte count and start address sit at index 3 and 4 for read and at index 6 and 7 for write.
- R6: Busy sets on the clock edge after a start write. Busy clears and done sets on the same edge once the byte countdown is zero; for a write, the write region must also be empty.
- R7: While the write direction is busy, one word per cycle leaves the head of the write region. Each word taken while bytes remain appears one cycle later on the flash write strobe. Its address is the start address plus 4 per word, and bytes beyond the remaining count are zero. Words taken after the count is used up are discarded.
- R8: While the read direction is busy, bytes remain and the read region is not full, one word per cycle enters the read region. The word equals its byte address XOR 0xC3A55A3C, with bytes beyond the remaining count zeroed. A full region stalls the transfer with busy held.
- R9: The data port pops the oldest read-region word. The read data output shows that word before the pop and reads 0 while the region is empty. Pushed words reach the flash side in push order.
- R10: A push into a full write region or a pop from an empty read region changes nothing else. It sets error bit 0 (push) or bit 1 (pop) at register index 8. The bit stays set until 1 is written to it.
- R11: Writing 1 to cancel clears busy without setting done and empties that direction's region. Cancel takes priority over a start in the same write.
- R12: A start with a byte count of 0 moves no words and sets done one edge after busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| dp_push | input | 1 | Push dp_wdata into the write region |
| dp_wdata | input | 32 | Data port write word |
| dp_pop | input | 1 | Pop the head word of the read region |
| dp_rdata | output | 32 | Head word of the read region, 0 when empty |
| flw_valid | output | 1 | Flash-side write strobe |
| flw_addr | output | 32 | Byte address of the flash-side write |
| flw_data | output | 32 | Flash-side write word with invalid bytes zeroed |

## Verification
The assertions assume that register writes are single-cycle strobes and that no register write is issued while reset is held. Under those conditions, a falling busy flag without a cancel in the previous cycle implies done, and fill levels never exceed their region sizes. The bench changes the partition only when both directions are idle. The one exception is the deliberate R3 probe, which writes it while a stalled read is busy. Random write transfers never push more words than the write region holds, and their byte counts fall inside the last pushed word. Random read lengths may exceed the read region, which exercises the stall path while the bench pops whatever has arrived.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;

    localparam int unsigned WORD_W     = 32;
    localparam int unsigned WORD_BYTES = 4;

    typedef enum logic [3:0] {
        REG_PART    = 4'd0,
        REG_LEVEL   = 4'd1,
        REG_RD_CTRL = 4'd2,
        REG_RD_LEN  = 4'd3,
        REG_RD_ADDR = 4'd4,
        REG_WR_CTRL = 4'd5,
        REG_WR_LEN  = 4'd6,
        REG_WR_ADDR = 4'd7,
        REG_ERR     = 4'd8
    } reg_sel_e;

    // control register bit positions
    localparam int unsigned CB_START  = 0;
    localparam int unsigned CB_CANCEL = 1;
    localparam int unsigned CB_BUSY   = 2;
    localparam int unsigned CB_DONE   = 5;

    localparam logic [WORD_W-1:0] RD_PATTERN = 32'hC3A5_5A3C;

    typedef struct packed {
        logic start;
        logic cancel;
        logic done_clr;
    } xfer_cmd_t;

    // zero the bytes of a word that lie beyond the remaining byte count
    function automatic logic [WORD_W-1:0] keep_bytes(input logic [WORD_W-1:0] w,
                                                     input logic [31:0] left);
        logic [WORD_W-1:0] m;
        case (left)
            32'd0:   m = 32'h0000_0000;
            32'd1:   m = 32'h0000_00FF;
            32'd2:   m = 32'h0000_FFFF;
            32'd3:   m = 32'h00FF_FFFF;
            default: m = 32'hFFFF_FFFF;
        endcase
        return w & m;
    endfunction

    function automatic logic [WORD_W-1:0] ctrl_word(input logic busy, input logic done);
        logic [WORD_W-1:0] v;
        v = '0;
        v[CB_BUSY] = busy;
        v[CB_DONE] = done;
        return v;
    endfunction

    function automatic xfer_cmd_t decode_cmd(input logic hit, input logic [WORD_W-1:0] d);
        xfer_cmd_t c;
        c.start    = hit && d[CB_START];
        c.cancel   = hit && d[CB_CANCEL];
        c.done_clr = hit && d[CB_DONE];
        return c;
    endfunction

endpackage

// File: rtl/sbuf_region.sv
module sbuf_region #(
    parameter int unsigned DEPTH = 128
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         flush,
    input  logic [$clog2(DEPTH)-1:0]     base,
    input  logic [$clog2(DEPTH):0]       size,
    input  logic                         push,
    input  logic                         pop,
    output logic [$clog2(DEPTH)-1:0]     push_addr,
    output logic [$clog2(DEPTH)-1:0]     head_addr,
    output logic [$clog2(DEPTH):0]       level,
    output logic                         full,
    output logic                         empty
);
    localparam int unsigned AW = $clog2(DEPTH);
    localparam int unsigned LW = AW + 1;

    logic [AW-1:0] wr_off;
    logic [AW-1:0] rd_off;
    logic          do_push;
    logic          do_pop;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] off,
                                           input logic [LW-1:0] lim);
        if (({1'b0, off} + LW'(1)) == lim) return '0;
        return off + AW'(1);
    endfunction

    assign full      = (level >= size);
    assign empty     = (level == '0);
    assign do_push   = push && !full;
    assign do_pop    = pop && !empty;
    assign push_addr = base + wr_off;
    assign head_addr = base + rd_off;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_off <= '0;
            rd_off <= '0;
            level  <= '0;
        end else begin
            if (do_push) wr_off <= bump(wr_off, size);
            if (do_pop)  rd_off <= bump(rd_off, size);
            level <= level + LW'(do_push) - LW'(do_pop);
        end
    end

endmodule

// File: rtl/sbuf_xfer_ctrl.sv
module sbuf_xfer_ctrl
    import sbuf_pkg::*;
#(
    parameter int unsigned LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  xfer_cmd_t        cmd,
    input  logic [LEN_W-1:0] len,
    input  logic [31:0]      addr,
    input  logic             step,
    input  logic             drained,
    output logic             busy,
    output logic             done,
    output logic [LEN_W-1:0] remain,
    output logic [31:0]      cur_addr
);
    logic [LEN_W-1:0] take;
    logic             finish;

    assign take   = (remain >= LEN_W'(WORD_BYTES)) ? LEN_W'(WORD_BYTES) : remain;
    assign finish = busy && !cmd.cancel && (remain == '0) && drained;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            done     <= 1'b0;
            remain   <= '0;
            cur_addr <= '0;
        end else begin
            if (cmd.cancel) begin
                busy   <= 1'b0;
                remain <= '0;
            end else if (cmd.start && !busy) begin
                busy     <= 1'b1;
                remain   <= len;
                cur_addr <= addr;
            end else if (finish) begin
                busy <= 1'b0;
            end else if (busy && step) begin
                remain   <= remain - take;
                cur_addr <= cur_addr + 32'd4;
            end

            if (finish)            done <= 1'b1;
            else if (cmd.done_clr) done <= 1'b0;
        end
    end

endmodule

// File: rtl/sbuf_flash_stub.sv
module sbuf_flash_stub
    import sbuf_pkg::*;
#(
    parameter int unsigned LEN_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_busy,
    input  logic [LEN_W-1:0]  rd_remain,
    input  logic [31:0]       rd_addr,
    input  logic              rd_full,
    output logic              rd_push,
    output logic [WORD_W-1:0] rd_word,
    input  logic              wr_busy,
    input  logic [LEN_W-1:0]  wr_remain,
    input  logic [31:0]       wr_addr,
    input  logic              wr_empty,
    input  logic [WORD_W-1:0] wr_head,
    output logic              wr_pop,
    output logic              wr_step,
    output logic              flw_valid,
    output logic [31:0]       flw_addr,
    output logic [WORD_W-1:0] flw_data
);
    // read side: generate one word per cycle while room remains
    assign rd_push = rd_busy && (rd_remain != '0) && !rd_full;
    assign rd_word = keep_bytes(rd_addr ^ RD_PATTERN, 32'(rd_remain));

    // write side: drain one word per cycle, emit it while bytes remain
    assign wr_pop  = wr_busy && !wr_empty;
    assign wr_step = wr_pop && (wr_remain != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            flw_valid <= 1'b0;
            flw_addr  <= '0;
            flw_data  <= '0;
        end else begin
            flw_valid <= wr_step;
            if (wr_step) begin
                flw_addr <= wr_addr;
                flw_data <= keep_bytes(wr_head, 32'(wr_remain));
            end
        end
    end

endmodule

// File: rtl/sbuf_xfer_buffer.sv
module sbuf_xfer_buffer
    import sbuf_pkg::*;
#(
    parameter int unsigned DEPTH      = 128,
    parameter int unsigned RESV       = 2,
    parameter int unsigned LEN_W      = 16,
    parameter int unsigned PART_RESET = 64
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_we,
    input  logic [3:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        dp_push,
    input  logic [31:0] dp_wdata,
    input  logic        dp_pop,
    output logic [31:0] dp_rdata,
    output logic        flw_valid,
    output logic [31:0] flw_addr,
    output logic [31:0] flw_data
);
    localparam int unsigned AW     = $clog2(DEPTH);
    localparam int unsigned LW     = AW + 1;
    localparam int unsigned USABLE = DEPTH - RESV;

    // ---------------- register state ----------------
    logic [LW-1:0]    part_q;
    logic [LEN_W-1:0] rd_len_q, wr_len_q;
    logic [31:0]      rd_addr_q, wr_addr_q;
    logic [1:0]       err_q;

    logic      hit_part, hit_rdc, hit_wrc, hit_err;
    logic      part_accept;
    xfer_cmd_t rd_cmd, wr_cmd;

    // ---------------- datapath wires ----------------
    logic             rd_busy, rd_done, wr_busy, wr_done;
    logic [LEN_W-1:0] rd_remain, wr_remain;
    logic [31:0]      rd_cur, wr_cur;
    logic             rd_flush, wr_flush;
    logic [AW-1:0]    rd_push_addr, rd_head_addr, wr_push_addr, wr_head_addr;
    logic [LW-1:0]    rd_level, wr_level, wr_size;
    logic             rd_full, rd_empty, wr_full, wr_empty;
    logic             stub_rd_push, stub_wr_pop, stub_wr_step;
    logic [31:0]      stub_rd_word, wr_head_word;
    logic             push_err, pop_err;
    logic [31:0]      mem [DEPTH];

    assign hit_part = reg_we && (reg_addr == REG_PART);
    assign hit_rdc  = reg_we && (reg_addr == REG_RD_CTRL);
    assign hit_wrc  = reg_we && (reg_addr == REG_WR_CTRL);
    assign hit_err  = reg_we && (reg_addr == REG_ERR);

    assign rd_cmd = decode_cmd(hit_rdc, reg_wdata);
    assign wr_cmd = decode_cmd(hit_wrc, reg_wdata);

    assign part_accept = hit_part && !rd_busy && !wr_busy;
    assign rd_flush    = part_accept || rd_cmd.cancel;
    assign wr_flush    = part_accept || wr_cmd.cancel;
    assign wr_size     = LW'(USABLE) - part_q;

    assign push_err = dp_push && wr_full;
    assign pop_err  = dp_pop && rd_empty;

    always_ff @(posedge clk) begin
        if (rst) begin
            part_q    <= LW'(PART_RESET);
            rd_len_q  <= '0;
            wr_len_q  <= '0;
            rd_addr_q <= '0;
            wr_addr_q <= '0;
            err_q     <= '0;
        end else begin
            if (part_accept)
                part_q <= (reg_wdata > 32'(USABLE)) ? LW'(USABLE) : reg_wdata[LW-1:0];
            if (reg_we && reg_addr == REG_RD_LEN)  rd_len_q  <= reg_wdata[LEN_W-1:0];
            if (reg_we && reg_addr == REG_RD_ADDR) rd_addr_q <= reg_wdata;
            if (reg_we && reg_addr == REG_WR_LEN)  wr_len_q  <= reg_wdata[LEN_W-1:0];
            if (reg_we && reg_addr == REG_WR_ADDR) wr_addr_q <= reg_wdata;
            err_q <= (err_q & ~(hit_err ? reg_wdata[1:0] : 2'b00)) | {pop_err, push_err};
        end
    end

    always_comb begin
        case (reg_addr)
            REG_PART:    reg_rdata = 32'(part_q);
            REG_LEVEL:   reg_rdata = {16'(wr_level), 16'(rd_level)};
            REG_RD_CTRL: reg_rdata = ctrl_word(rd_busy, rd_done);
            REG_RD_LEN:  reg_rdata = 32'(rd_len_q);
            REG_RD_ADDR: reg_rdata = rd_addr_q;
            REG_WR_CTRL: reg_rdata = ctrl_word(wr_busy, wr_done);
            REG_WR_LEN:  reg_rdata = 32'(wr_len_q);
            REG_WR_ADDR: reg_rdata = wr_addr_q;
            REG_ERR:     reg_rdata = 32'(err_q);
            default:     reg_rdata = '0;
        endcase
    end

    // ---------------- per-direction control ----------------
    sbuf_xfer_ctrl #(.LEN_W(LEN_W)) u_rd_ctrl (
        .clk(clk), .rst(rst), .cmd(rd_cmd), .len(rd_len_q), .addr(rd_addr_q),
        .step(stub_rd_push), .drained(1'b1),
        .busy(rd_busy), .done(rd_done), .remain(rd_remain), .cur_addr(rd_cur)
    );

    sbuf_xfer_ctrl #(.LEN_W(LEN_W)) u_wr_ctrl (
        .clk(clk), .rst(rst), .cmd(wr_cmd), .len(wr_len_q), .addr(wr_addr_q),
        .step(stub_wr_step), .drained(wr_empty),
        .busy(wr_busy), .done(wr_done), .remain(wr_remain), .cur_addr(wr_cur)
    );

    // ---------------- regions of the shared array ----------------
    sbuf_region #(.DEPTH(DEPTH)) u_rd_region (
        .clk(clk), .rst(rst), .flush(rd_flush),
        .base('0), .size(part_q),
        .push(stub_rd_push), .pop(dp_pop),
        .push_addr(rd_push_addr), .head_addr(rd_head_addr),
        .level(rd_level), .full(rd_full), .empty(rd_empty)
    );

    sbuf_region #(.DEPTH(DEPTH)) u_wr_region (
        .clk(clk), .rst(rst), .flush(wr_flush),
        .base(part_q[AW-1:0]), .size(wr_size),
        .push(dp_push), .pop(stub_wr_pop),
        .push_addr(wr_push_addr), .head_addr(wr_head_addr),
        .level(wr_level), .full(wr_full), .empty(wr_empty)
    );

    // two write ports land in disjoint regions of the array
    always_ff @(posedge clk) begin
        if (stub_rd_push)         mem[rd_push_addr] <= stub_rd_word;
        if (dp_push && !wr_full)  mem[wr_push_addr] <= dp_wdata;
    end

    assign dp_rdata     = rd_empty ? '0 : mem[rd_head_addr];
    assign wr_head_word = mem[wr_head_addr];

    // ---------------- flash-side stand-in ----------------
    sbuf_flash_stub #(.LEN_W(LEN_W)) u_stub (
        .clk(clk), .rst(rst),
        .rd_busy(rd_busy), .rd_remain(rd_remain), .rd_addr(rd_cur), .rd_full(rd_full),
        .rd_push(stub_rd_push), .rd_word(stub_rd_word),
        .wr_busy(wr_busy), .wr_remain(wr_remain), .wr_addr(wr_cur), .wr_empty(wr_empty),
        .wr_head(wr_head_word), .wr_pop(stub_wr_pop), .wr_step(stub_wr_step),
        .flw_valid(flw_valid), .flw_addr(flw_addr), .flw_data(flw_data)
    );

endmodule

// File: rtl/sbuf_xfer_buffer_chk.sv
module sbuf_xfer_buffer_chk
    import sbuf_pkg::*;
#(
    parameter int unsigned DEPTH = 128,
    parameter int unsigned RESV  = 2
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     reg_we,
    input logic [3:0]               reg_addr,
    input logic [31:0]              reg_wdata,
    input logic                     dp_push,
    input logic [$clog2(DEPTH):0]   part_q,
    input logic [$clog2(DEPTH):0]   rd_level,
    input logic [$clog2(DEPTH):0]   wr_level,
    input logic                     wr_full,
    input logic                     rd_busy,
    input logic                     wr_busy,
    input logic                     rd_done,
    input logic                     wr_done,
    input logic [1:0]               err_q,
    input logic                     flw_valid
);
    localparam int unsigned LW     = $clog2(DEPTH) + 1;
    localparam int unsigned USABLE = DEPTH - RESV;

    logic rd_cancel_w, wr_cancel_w;
    assign rd_cancel_w = reg_we && reg_addr == REG_RD_CTRL && reg_wdata[CB_CANCEL];
    assign wr_cancel_w = reg_we && reg_addr == REG_WR_CTRL && reg_wdata[CB_CANCEL];

    // R6: busy only falls without cancel by completing, which raises done
    a_r6_rd_done_on_end: assert property (@(posedge clk) disable iff (rst)
        ($fell(rd_busy) && !$past(rd_cancel_w)) |-> rd_done);
    a_r6_wr_done_on_end: assert property (@(posedge clk) disable iff (rst)
        ($fell(wr_busy) && !$past(wr_cancel_w)) |-> wr_done);

    // R2: fill levels stay within the region sizes
    a_r2_level_bound: assert property (@(posedge clk) disable iff (rst)
        (rd_level <= part_q) && (wr_level <= LW'(USABLE) - part_q));

    // R3: partition frozen while any direction is busy
    a_r3_part_frozen: assert property (@(posedge clk) disable iff (rst)
        (rd_busy || wr_busy) |=> $stable(part_q));

    // R10: overflowing push leaves the sticky flag set
    a_r10_overflow_flag: assert property (@(posedge clk) disable iff (rst)
        (dp_push && wr_full) |=> err_q[0]);

    // R7: flash writes only follow a busy write direction
    a_r7_flw_needs_busy: assert property (@(posedge clk) disable iff (rst)
        flw_valid |-> $past(wr_busy));

    // R11: cancel empties the read region and drops busy
    a_r11_cancel_empties: assert property (@(posedge clk) disable iff (rst)
        $past(rd_cancel_w) |-> (!rd_busy && rd_level == '0));

endmodule

bind sbuf_xfer_buffer sbuf_xfer_buffer_chk #(.DEPTH(DEPTH), .RESV(RESV)) u_chk (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .dp_push(dp_push), .part_q(part_q), .rd_level(rd_level), .wr_level(wr_level),
    .wr_full(wr_full), .rd_busy(rd_busy), .wr_busy(wr_busy), .rd_done(rd_done),
    .wr_done(wr_done), .err_q(err_q), .flw_valid(flw_valid)
);

// File: tb/sbuf_xfer_buffer_test.sv
`timescale 1ns/1ps
module sbuf_xfer_buffer_test;

    localparam logic [3:0] A_PART = 4'd0, A_LEVEL = 4'd1, A_RDC = 4'd2, A_RDLEN = 4'd3,
                           A_RDADDR = 4'd4, A_WRC = 4'd5, A_WRLEN = 4'd6, A_WRADDR = 4'd7,
                           A_ERR = 4'd8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        dp_push = 1'b0;
    logic [31:0] dp_wdata = '0;
    logic        dp_pop = 1'b0;
    logic [31:0] dp_rdata;
    logic        flw_valid;
    logic [31:0] flw_addr, flw_data;

    int nvec = 0;
    int nbad = 0;
    logic [31:0] fa_q[$];
    logic [31:0] fd_q[$];
    logic [31:0] wd_q[$];

    always #2.5 clk = ~clk;

    sbuf_xfer_buffer uut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .dp_push(dp_push), .dp_wdata(dp_wdata), .dp_pop(dp_pop),
        .dp_rdata(dp_rdata), .flw_valid(flw_valid), .flw_addr(flw_addr), .flw_data(flw_data)
    );

    always @(negedge clk) if (!rst && flw_valid) begin
        fa_q.push_back(flw_addr);
        fd_q.push_back(flw_data);
    end

    function automatic logic [31:0] mask_of(input int left);
        if (left >= 4) return 32'hFFFF_FFFF;
        if (left <= 0) return 32'h0;
        return (32'h1 << (8 * left)) - 32'h1;
    endfunction

    function automatic logic [31:0] exp_rd(input logic [31:0] a, input int left);
        return (a ^ 32'hC3A5_5A3C) & mask_of(left);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s: got %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_reg(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic push(input logic [31:0] w);
        @(negedge clk);
        dp_push = 1'b1; dp_wdata = w;
        @(negedge clk);
        dp_push = 1'b0;
    endtask

    task automatic pop(output logic [31:0] w);
        @(negedge clk);
        w = dp_rdata;
        dp_pop = 1'b1;
        @(negedge clk);
        dp_pop = 1'b0;
    endtask

    task automatic wait_idle(input logic [3:0] a, input string req);
        logic [31:0] v;
        for (int i = 0; i < 4000; i++) begin
            rd_reg(a, v);
            if (!v[2]) return;
        end
        chk(req, 32'hDEAD, 32'h0);
    endtask

    task automatic run_write(input int nw, input int len, input logic [31:0] addr);
        int nexp;
        fa_q.delete(); fd_q.delete(); wd_q.delete();
        for (int i = 0; i < nw; i++) begin
            logic [31:0] w;
            w = $urandom;
            wd_q.push_back(w);
            push(w);
        end
        wr_reg(A_WRLEN, len);
        wr_reg(A_WRADDR, addr);
        wr_reg(A_WRC, 32'h1);
        wait_idle(A_WRC, "R6");
        begin
            logic [31:0] v;
            rd_reg(A_WRC, v);
            chk("R6 write done", v, 32'h20);
            rd_reg(A_LEVEL, v);
            chk("R7 region drained", v, 32'h0);
        end
        nexp = (len + 3) / 4;
        chk("R7 write count", fa_q.size(), nexp);
        for (int k = 0; k < nexp && k < fa_q.size(); k++) begin
            chk("R7 write addr", fa_q[k], addr + 4 * k);
            chk("R9 write data order", fd_q[k], wd_q[k] & mask_of(len - 4 * k));
        end
        wr_reg(A_WRC, 32'h20);
    endtask

    task automatic run_read(input int len, input logic [31:0] addr);
        int nw;
        logic [31:0] v, w;
        nw = (len + 3) / 4;
        wr_reg(A_RDLEN, len);
        wr_reg(A_RDADDR, addr);
        wr_reg(A_RDC, 32'h1);
        for (int k = 0; k < nw; k++) begin
            v = 0;
            for (int t = 0; t < 200 && v[15:0] == 0; t++) rd_reg(A_LEVEL, v);
            pop(w);
            chk("R8 read word", w, exp_rd(addr + 4 * k, len - 4 * k));
        end
        wait_idle(A_RDC, "R6");
        rd_reg(A_RDC, v);
        chk("R6 read done", v, 32'h20);
        rd_reg(A_LEVEL, v);
        chk("R8 no extra words", v, 32'h0);
        wr_reg(A_RDC, 32'h20);
    endtask

    initial begin
        #(5.0 * 150000);
        nbad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        logic [31:0] v, w;
        void'($urandom(32'd4711));
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd_reg(A_LEVEL, v); chk("R1 level", v, 0);
        rd_reg(A_PART, v);  chk("R1 partition", v, 64);
        rd_reg(A_RDC, v);   chk("R1 rd ctrl", v, 0);
        rd_reg(A_WRC, v);   chk("R1 wr ctrl", v, 0);
        rd_reg(A_ERR, v);   chk("R1 err", v, 0);
        chk("R9 empty rdata", dp_rdata, 0);

        // R4 write level in upper half, R10 pop underflow
        push(32'h1111_1111); push(32'h2222_2222); push(32'h3333_3333);
        rd_reg(A_LEVEL, v); chk("R4 write level", v, 32'h0003_0000);
        pop(w);
        chk("R9 empty pop data", w, 0);
        rd_reg(A_ERR, v);   chk("R10 underflow flag", v, 32'h2);
        rd_reg(A_LEVEL, v); chk("R10 underflow no effect", v, 32'h0003_0000);
        wr_reg(A_ERR, 32'h2);
        rd_reg(A_ERR, v);   chk("R10 flag clear", v, 0);

        // R2 saturation and flush; zero-size write region overflows
        wr_reg(A_PART, 200);
        rd_reg(A_PART, v);  chk("R2 saturate", v, 126);
        rd_reg(A_LEVEL, v); chk("R2 flush", v, 0);
        push(32'hABCD_0000);
        rd_reg(A_ERR, v);   chk("R10 overflow flag", v, 32'h1);
        rd_reg(A_LEVEL, v); chk("R10 overflow no effect", v, 0);
        wr_reg(A_ERR, 32'h1);

        // fill a 26-word write region then overflow
        wr_reg(A_PART, 100);
        fa_q.delete(); fd_q.delete(); wd_q.delete();
        for (int i = 0; i < 26; i++) begin
            w = $urandom; wd_q.push_back(w); push(w);
        end
        rd_reg(A_LEVEL, v); chk("R2 write region size", v, 32'h001A_0000);
        push(32'h5555_5555);
        rd_reg(A_ERR, v);   chk("R10 full push", v, 32'h1);
        wr_reg(A_ERR, 32'h1);
        wr_reg(A_WRLEN, 101);
        wr_reg(A_WRADDR, 32'h1000);
        wr_reg(A_WRC, 32'h1);
        wait_idle(A_WRC, "R6");
        chk("R7 partial count", fa_q.size(), 26);
        if (fa_q.size() == 26) begin
            chk("R7 last addr", fa_q[25], 32'h1064);
            chk("R7 last partial", fd_q[25], wd_q[25] & 32'hFF);
            chk("R9 first word", fd_q[0], wd_q[0]);
        end
        rd_reg(A_WRC, v);   chk("R6 done after drain", v, 32'h20);
        wr_reg(A_WRC, 32'h20);
        rd_reg(A_WRC, v);   chk("R5 done w1c", v, 0);

        // R7 extra words discarded
        run_write(5, 8, 32'h0000_3000);

        // R12 zero byte transfers
        fa_q.delete();
        wr_reg(A_WRLEN, 0); wr_reg(A_WRC, 32'h1);
        repeat (3) @(negedge clk);
        rd_reg(A_WRC, v);   chk("R12 write zero", v, 32'h20);
        chk("R12 no flash writes", fa_q.size(), 0);
        wr_reg(A_WRC, 32'h20);
        wr_reg(A_RDLEN, 0); wr_reg(A_RDC, 32'h1);
        repeat (3) @(negedge clk);
        rd_reg(A_RDC, v);   chk("R12 read zero", v, 32'h20);
        rd_reg(A_LEVEL, v); chk("R12 no read words", v, 0);
        wr_reg(A_RDC, 32'h20);

        // R8 stall in a small region, R3 partition frozen
        wr_reg(A_PART, 8);
        wr_reg(A_RDLEN, 200); wr_reg(A_RDADDR, 32'h0000_2000); wr_reg(A_RDC, 32'h1);
        repeat (20) @(negedge clk);
        rd_reg(A_LEVEL, v); chk("R8 stall full", v, 8);
        rd_reg(A_RDC, v);   chk("R8 busy held", v, 32'h4);
        wr_reg(A_PART, 20);
        rd_reg(A_PART, v);  chk("R3 partition frozen", v, 8);
        pop(w);             chk("R9 head word", w, exp_rd(32'h2000, 200));
        // R11 cancel
        wr_reg(A_RDC, 32'h2);
        rd_reg(A_RDC, v);   chk("R11 cancel no done", v, 0);
        rd_reg(A_LEVEL, v); chk("R11 cancel flush", v, 0);
        wr_reg(A_RDLEN, 40); wr_reg(A_RDC, 32'h3);
        repeat (4) @(negedge clk);
        rd_reg(A_RDC, v);   chk("R11 cancel beats start", v, 0);
        rd_reg(A_LEVEL, v); chk("R11 nothing produced", v, 0);

        // directed stalled read through a small region
        run_read(50, 32'h0000_2000);

        // constrained random mix
        for (int it = 0; it < 8; it++) begin
            int p, nw, len;
            p = 16 + ($urandom % 85);
            wr_reg(A_PART, p);
            rd_reg(A_PART, v); chk("R2 partition", v, p);
            if ($urandom % 2) begin
                nw  = 1 + ($urandom % ((126 - p) < 40 ? (126 - p) : 40));
                len = (nw - 1) * 4 + 1 + ($urandom % 4);
                run_write(nw, len, {$urandom} & 32'hFFFF_FFFC);
            end else begin
                len = 1 + ($urandom % (8 * p));
                run_read(len, {$urandom} & 32'hFFFF_FFFC);
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

endmodule